// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block pairs two eight-line priority controllers, a primary and a secondary, into one sixteen-line interrupt source for a processor. The secondary controller reports its request into primary line 2, which is reserved for cascading: the external signal on that line is not used. The unit raises a single sticky pending flag toward the processor. When the processor answers with an acknowledge strobe, the unit picks the winning line, updates the request and in-service state of both controllers, and returns an 8-bit vector and a 4-bit global line number.

Each controller has a fixed priority: the lower line number wins. A request is served only if it outranks everything currently in service on that controller. Trigger mode, masks, auto end-of-service, the cascade nesting mode and the two vector bases are held in registers outside this unit and arrive here as plain inputs. An end-of-service strobe, aimed at either controller, clears that controller's highest-ranked in-service bit. If nothing valid is left to serve at acknowledge time, the unit returns line 7 of the controller concerned and pulses a spurious indication.

Top module: `casc_intr_ack`

## Requirements
- R1: Primary line n (n in 0..7, n not 2) with a request that is not masked returns vector `base_pri + n` and number n. When several lines request at once, the lowest line number wins.
- R2: Secondary line 8+k (k in 0..7) returns vector `base_sec + k` and number 8+k, after it has passed through primary line 2.
- R3: `pending` rises within a few cycles of a request that can win. It stays high, even if the request later disappears, until `ack` is sampled. It is 0 on the cycle after an acknowledge, and it rises again if a winner still remains.
- R4: An in-service bit blocks requests of equal or lower priority on its controller. A higher-priority request still raises `pending` and is served (nesting).
- R5: `eoi` with `eoi_sec`=0 clears the primary's highest-ranked in-service bit. With `eoi_sec`=1 it does the same on the secondary.
- R6: With `auto_eoi[0]` (primary) or `auto_eoi[1]` (secondary) set, an acknowledge sets no in-service bit on that controller.
- R7: `level_sel[i]`=1 selects level mode: the line keeps its request while it is high, and an acknowledge does not clear it. Level mode is honoured only where the mask 0xF8 (primary, bits = lines 0..7) or 0xDE (secondary, bits = lines 8..15) has a 1. Lines 0, 1, 2, 8 and 13 are always edge triggered: each rising edge latches one request.
- R8: `irq_in[2]` has no effect. Primary line 2 is set only by a winning secondary request.
- R9: With `nest_sfn`=1, the primary leaves its in-service bit 2 out of its current-priority test, so a higher-priority secondary line can nest over a secondary line already in service.
- R10: An acknowledge with no primary winner returns `base_pri + 7`, number 7, and `spurious`=1, and changes no request or in-service bit.
- R11: An acknowledge whose primary winner is line 2 while the secondary has no winner returns `base_sec + 7`, number 15, and `spurious`=1. No secondary in-service bit changes, and primary line 2 is marked in service.
- R12: `vector` and `irq_num` are valid on the cycle after `ack` and hold until the next acknowledge. `spurious` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Interrupt lines; bit i is global line i (bit 2 unused) |
| irq_mask | input | 16 | 1 masks the line; bit 2 masks the cascade |
| level_sel | input | 16 | 1 requests level mode for the line, subject to the fixed masks |
| auto_eoi | input | 2 | Bit 0 primary, bit 1 secondary: no in-service on acknowledge |
| nest_sfn | input | 1 | Leave primary in-service bit 2 out of the primary's priority test |
| base_pri | input | 8 | Vector base of the primary |
| base_sec | input | 8 | Vector base of the secondary |
| ack | input | 1 | Acknowledge strobe, one cycle |
| eoi | input | 1 | End-of-service strobe, one cycle |
| eoi_sec | input | 1 | 0 aims `eoi` at the primary, 1 at the secondary |
| pending | output | 1 | Sticky interrupt request toward the processor |
| vector | output | 8 | Vector of the last acknowledge |
| irq_num | output | 4 | Global line number of the last acknowledge |
| spurious | output | 1 | One-cycle flag: the last acknowledge found no valid winner |

## Verification
A wrong request bit or a lost edge latch shows up as `pending` that never rises, or that rises for a line which should be blocked, two to three cycles after the stimulus, because cascaded requests pass through two register stages. A wrong in-service bit stays hidden until a later request: lower-priority lines stay blocked after an end-of-service, or equal-priority lines nest. So the bench follows every acknowledge with end-of-service and fresh requests, and checks which line comes back. Errors in the cascade and spurious paths appear directly in `vector`, `irq_num` and `spurious` on the cycle after the acknowledge.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int unsigned CTL_LINES = 8;
  localparam int unsigned CTL_IDW   = $clog2(CTL_LINES);

  typedef logic [CTL_LINES-1:0] line_vec_t;

  typedef enum logic [1:0] {
    SRC_PRI   = 2'd0,
    SRC_SEC   = 2'd1,
    SRC_SPURP = 2'd2,
    SRC_SPURS = 2'd3
  } ack_src_e;

  function automatic line_vec_t bit_at(input logic [CTL_IDW-1:0] idx);
    line_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/casc_prio_pick.sv
module casc_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
    valid = |req;
  end
endmodule

// File: rtl/casc_prio_core.sv
module casc_prio_core
  import casc_pkg::*;
#(
  parameter line_vec_t TRIG_MASK = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  line_vec_t          line_in,
  input  line_vec_t          set_in,
  input  line_vec_t          level_sel,
  input  line_vec_t          mask_in,
  input  line_vec_t          isr_skip,
  input  logic               ack_en,
  input  logic               eoi_en,
  input  logic               auto_eoi,
  output logic               win_v,
  output logic [CTL_IDW-1:0] win_idx,
  output line_vec_t          isr_o
);
  line_vec_t irr_q, isr_q, last_q;
  line_vec_t irr_d, isr_d;
  line_vec_t lvl, rise, ack_bit, eoi_bit;
  logic               req_v, cur_v, top_v;
  logic [CTL_IDW-1:0] req_i, cur_i, top_i;

  casc_prio_pick #(.N(CTL_LINES)) i_req_pick (
    .req(irr_q & ~mask_in), .valid(req_v), .idx(req_i));
  casc_prio_pick #(.N(CTL_LINES)) i_cur_pick (
    .req(isr_q & ~isr_skip), .valid(cur_v), .idx(cur_i));
  casc_prio_pick #(.N(CTL_LINES)) i_top_pick (
    .req(isr_q), .valid(top_v), .idx(top_i));

  always_comb begin
    win_v   = req_v && (!cur_v || (req_i < cur_i));
    win_idx = req_i;
    lvl     = level_sel & TRIG_MASK;
    rise    = line_in & ~last_q;
    ack_bit = (ack_en && win_v) ? bit_at(req_i) : '0;
    eoi_bit = (eoi_en && top_v) ? bit_at(top_i) : '0;
    irr_d   = (lvl & line_in) |
              (~lvl & ((irr_q & ~ack_bit) | rise | set_in));
    isr_d   = (isr_q | (auto_eoi ? '0 : ack_bit)) & ~eoi_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= line_in;
    end
  end

  assign isr_o = isr_q;

  AST_ISR_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |=> ((isr_q & ~$past(isr_q)) == '0)); // R4
  AST_ISR_ONE_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> ($countones(isr_q & ~$past(isr_q)) <= 1)); // R4
  AST_AUTO_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi |=> ((isr_q & ~$past(isr_q)) == '0)); // R6
  AST_EOI_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_en |=> ($countones($past(isr_q) & ~isr_q) <= 1)); // R5
endmodule

// File: rtl/casc_intr_ack.sv
module casc_intr_ack
  import casc_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CASC_LINE = 2,
  parameter line_vec_t   PRI_TRIG  = 8'hF8,
  parameter line_vec_t   SEC_TRIG  = 8'hDE,
  localparam int unsigned ALL_LINES = 2 * CTL_LINES,
  localparam int unsigned NUM_W     = CTL_IDW + 1,
  localparam logic [CTL_IDW-1:0] SPUR_IDX = CTL_IDW'(CTL_LINES - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ALL_LINES-1:0] irq_in,
  input  logic [ALL_LINES-1:0] irq_mask,
  input  logic [ALL_LINES-1:0] level_sel,
  input  logic [1:0]           auto_eoi,
  input  logic                 nest_sfn,
  input  logic [VEC_W-1:0]     base_pri,
  input  logic [VEC_W-1:0]     base_sec,
  input  logic                 ack,
  input  logic                 eoi,
  input  logic                 eoi_sec,
  output logic                 pending,
  output logic [VEC_W-1:0]     vector,
  output logic [NUM_W-1:0]     irq_num,
  output logic                 spurious
);
  localparam line_vec_t CASC_BIT = line_vec_t'(1) << CASC_LINE;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic               p_win, s_win, p_is_casc;
  logic [CTL_IDW-1:0] p_idx, s_idx;
  line_vec_t          p_isr, s_isr;

  assign p_is_casc = p_win && (p_idx == CTL_IDW'(CASC_LINE));

  casc_prio_core #(.TRIG_MASK(PRI_TRIG)) i_pri (
    .clk(clk), .rst_n(rst_sync_n),
    .line_in(irq_in[CTL_LINES-1:0] & ~CASC_BIT),
    .set_in((s_win && !ack) ? CASC_BIT : '0),
    .level_sel(level_sel[CTL_LINES-1:0]),
    .mask_in(irq_mask[CTL_LINES-1:0]),
    .isr_skip(nest_sfn ? CASC_BIT : '0),
    .ack_en(ack), .eoi_en(eoi && !eoi_sec), .auto_eoi(auto_eoi[0]),
    .win_v(p_win), .win_idx(p_idx), .isr_o(p_isr));

  casc_prio_core #(.TRIG_MASK(SEC_TRIG)) i_sec (
    .clk(clk), .rst_n(rst_sync_n),
    .line_in(irq_in[ALL_LINES-1:CTL_LINES]),
    .set_in('0),
    .level_sel(level_sel[ALL_LINES-1:CTL_LINES]),
    .mask_in(irq_mask[ALL_LINES-1:CTL_LINES]),
    .isr_skip('0),
    .ack_en(ack && p_is_casc), .eoi_en(eoi && eoi_sec), .auto_eoi(auto_eoi[1]),
    .win_v(s_win), .win_idx(s_idx), .isr_o(s_isr));

  ack_src_e           src;
  logic [VEC_W-1:0]   vec_d;
  logic [NUM_W-1:0]   num_d;
  logic               pend_d, spur_d;

  always_comb begin
    if (!p_win)        src = SRC_SPURP;
    else if (!p_is_casc) src = SRC_PRI;
    else if (s_win)    src = SRC_SEC;
    else               src = SRC_SPURS;
    unique case (src)
      SRC_PRI:   begin vec_d = base_pri + VEC_W'(p_idx);    num_d = {1'b0, p_idx};    end
      SRC_SEC:   begin vec_d = base_sec + VEC_W'(s_idx);    num_d = {1'b1, s_idx};    end
      SRC_SPURS: begin vec_d = base_sec + VEC_W'(SPUR_IDX); num_d = {1'b1, SPUR_IDX}; end
      default:   begin vec_d = base_pri + VEC_W'(SPUR_IDX); num_d = {1'b0, SPUR_IDX}; end
    endcase
    spur_d = ack && ((src == SRC_SPURP) || (src == SRC_SPURS));
    pend_d = ack ? 1'b0 : (pending || p_win);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pending  <= 1'b0;
      spurious <= 1'b0;
      vector   <= '0;
      irq_num  <= '0;
    end else begin
      pending  <= pend_d;
      spurious <= spur_d;
      if (ack) begin
        vector  <= vec_d;
        irq_num <= num_d;
      end
    end
  end

  AST_ACK_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack |=> !pending); // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pending && !ack) |=> pending); // R3
  AST_SPUR_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ack |=> !spurious); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ack |=> ($stable(vector) && $stable(irq_num))); // R12
  AST_PRI_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && !p_win && !eoi) |=> ($stable(p_isr) && $stable(s_isr) && spurious)); // R10
  AST_SEC_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && p_is_casc && !s_win && !(eoi && eoi_sec)) |=> ($stable(s_isr) && spurious)); // R11
endmodule

// File: tb/test_casc_intr_ack.sv
module test_casc_intr_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0, irq_mask = '0, level_sel = '0;
  logic [1:0]  auto_eoi = '0;
  logic        nest_sfn = 1'b0;
  logic [7:0]  base_pri = 8'h20, base_sec = 8'h70;
  logic        ack = 1'b0, eoi = 1'b0, eoi_sec = 1'b0;
  logic        pending, spurious;
  logic [7:0]  vector;
  logic [3:0]  irq_num;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  casc_intr_ack i_casc_intr_ack (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_mask(irq_mask),
    .level_sel(level_sel), .auto_eoi(auto_eoi), .nest_sfn(nest_sfn),
    .base_pri(base_pri), .base_sec(base_sec), .ack(ack), .eoi(eoi),
    .eoi_sec(eoi_sec), .pending(pending), .vector(vector),
    .irq_num(irq_num), .spurious(spurious));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line(input int ln);
    irq_in[ln] = 1'b1;
    tick(1);
    irq_in[ln] = 1'b0;
  endtask

  task automatic expect_pend(input string tag);
    bit got = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pending) begin got = 1'b1; break; end
      tick(1);
    end
    check(got, tag, int'(pending), 1);
  endtask

  task automatic expect_quiet(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pending) seen = 1'b1;
      tick(1);
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic do_ack(input int ev, input int en, input int es, input string tag);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    check(int'(vector) == ev, {tag, " vector"}, int'(vector), ev);
    check(int'(irq_num) == en, {tag, " number"}, int'(irq_num), en);
    check(int'(spurious) == es, {tag, " spurious"}, int'(spurious), es);
    check(!pending, {tag, " R3 pending after ack"}, int'(pending), 0);
    tick(1);
    check(!spurious, {tag, " R12 spurious width"}, int'(spurious), 0);
    check(int'(vector) == ev, {tag, " R12 hold"}, int'(vector), ev);
  endtask

  task automatic do_eoi(input bit sec);
    eoi = 1'b1; eoi_sec = sec;
    tick(1);
    eoi = 1'b0; eoi_sec = 1'b0;
  endtask

  task automatic serve(input int ln, input string tag);
    if (ln >= 8) do_ack(int'(base_sec) + ln - 8, ln, 0, tag);
    else         do_ack(int'(base_pri) + ln, ln, 0, tag);
  endtask

  task automatic close(input int ln);
    if (ln >= 8) do_eoi(1'b1);
    do_eoi(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check(!pending, "reset pending", int'(pending), 0);
    check(!spurious, "reset spurious", int'(spurious), 0);

    // R1 R2 R3: sweep every line alone, with two pairs of bases
    for (int pass = 0; pass < 2; pass++) begin
      base_pri = (pass == 0) ? 8'h20 : 8'h08;
      base_sec = (pass == 0) ? 8'h70 : 8'hA8;
      for (int ln = 0; ln < 16; ln++) begin
        if (ln == 2) continue;
        pulse_line(ln);
        expect_pend((ln >= 8) ? "R2 pending" : "R1 pending");
        serve(ln, (ln >= 8) ? "R2 sweep" : "R1 sweep");
        expect_quiet("R3 no repeat after ack");
        close(ln);
        expect_quiet("R5 clean after eoi");
      end
    end
    base_pri = 8'h20; base_sec = 8'h70;

    // R1 priority, R4 blocking, R5 eoi re-arms lower line
    irq_in[4] = 1'b1; irq_in[6] = 1'b1; tick(1); irq_in = '0;
    expect_pend("R1 pair pending");
    serve(4, "R1 lowest wins");
    expect_quiet("R4 line6 blocked by isr4");
    do_eoi(1'b0);
    expect_pend("R5 re-evaluated after eoi");
    serve(6, "R5 second line");
    do_eoi(1'b0);

    // R4 nesting
    pulse_line(5); expect_pend("R4 p5"); serve(5, "R4 first");
    pulse_line(3); expect_pend("R4 nest pending"); serve(3, "R4 nested");
    do_eoi(1'b0);
    pulse_line(6); expect_quiet("R4 line6 blocked by isr5");
    do_eoi(1'b0);
    expect_pend("R5 line6 after eoi"); serve(6, "R4 after");
    do_eoi(1'b0);

    // R6 auto end-of-service on the primary
    auto_eoi = 2'b01;
    pulse_line(5); expect_pend("R6 p5"); serve(5, "R6 first");
    pulse_line(6); expect_pend("R6 no isr block"); serve(6, "R6 second");
    auto_eoi = 2'b00;
    expect_quiet("R6 idle");

    // R9 special nesting on the cascade line
    nest_sfn = 1'b1;
    pulse_line(9); expect_pend("R9 p9"); serve(9, "R9 first");
    pulse_line(8); expect_pend("R9 nest pending"); serve(8, "R9 nested");
    do_eoi(1'b1); do_eoi(1'b1); do_eoi(1'b0);
    nest_sfn = 1'b0;
    pulse_line(9); expect_pend("R9 off p9"); serve(9, "R9 off first");
    pulse_line(8); expect_quiet("R9 off blocked");
    do_eoi(1'b1);
    expect_quiet("R9 still blocked by pri isr2");
    do_eoi(1'b0);
    expect_pend("R9 released"); serve(8, "R9 off second");
    close(8);

    // R7 level mode and forced-edge lines
    level_sel = 16'hFFFF;
    irq_in[3] = 1'b1;
    expect_pend("R7 level p3"); serve(3, "R7 level first");
    do_eoi(1'b0);
    expect_pend("R7 level persists"); serve(3, "R7 level again");
    irq_in[3] = 1'b0; tick(1);
    do_eoi(1'b0);
    expect_quiet("R7 level dropped");
    irq_in[0] = 1'b1;
    expect_pend("R7 forced edge p0"); serve(0, "R7 edge line0");
    do_eoi(1'b0);
    expect_quiet("R7 line0 edge once");
    irq_in[0] = 1'b0;
    irq_in[13] = 1'b1;
    expect_pend("R7 forced edge p13"); serve(13, "R7 edge line13");
    close(13);
    expect_quiet("R7 line13 edge once");
    irq_in[13] = 1'b0;
    irq_in[11] = 1'b1;
    expect_pend("R7 level p11"); serve(11, "R7 level sec");
    close(11);
    expect_pend("R7 level sec persists"); serve(11, "R7 level sec again");
    irq_in[11] = 1'b0; tick(1);
    close(11);
    level_sel = '0;

    // R8 external line 2 ignored
    pulse_line(2);
    expect_quiet("R8 irq_in2 ignored");
    irq_in[2] = 1'b1; level_sel[2] = 1'b1;
    expect_quiet("R8 irq_in2 held ignored");
    irq_in[2] = 1'b0; level_sel = '0;

    // R10 primary spurious
    pulse_line(4); expect_pend("R10 p4");
    irq_mask[4] = 1'b1; tick(1);
    do_ack(int'(base_pri) + 7, 7, 1, "R10 spurious");
    irq_mask = '0;
    expect_pend("R10 request kept"); serve(4, "R10 line4 after");
    do_eoi(1'b0);

    // R11 secondary spurious
    pulse_line(12); expect_pend("R11 p12");
    irq_mask[12] = 1'b1; tick(1);
    do_ack(int'(base_sec) + 7, 15, 1, "R11 spurious");
    irq_mask = '0;
    expect_quiet("R11 pri isr2 set");
    do_eoi(1'b0);
    expect_pend("R11 request kept"); serve(12, "R11 line12 after");
    close(12);
    expect_quiet("R11 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule